// File: doc/BRIEF.md
# Quasi-Resonant Restart Sequencer

This block decides, clock by clock, when the primary switch of a valley-switched flyback converter turns on and off. It works only on flags that have already been digitized and synchronized upstream. These are a current-sense trip, a demagnetization flag (high while the auxiliary winding sits below its zero-crossing threshold), a burst-mode skip request and an external fault. From them it produces the gate command, a sticky on-time fault flag and a one-cycle soft-start request.

A new switching period starts on a rising edge of the demagnetization flag, which marks a ringing valley. That edge is accepted only when three things hold: the whole on-plus-off period has already reached the frequency clamp, the blanking window after turn-off is over, and nothing holds the drive in reset. When the ringing has decayed so far that no edge arrives, a valley timeout grants the restart instead. The on-time ends on a current trip, which is ignored during a leading-edge blanking window, or on the maximum on-time guard. All durations are parameters counted in clock cycles.

Top module: `qr_restart_seq`

## Requirements
- R1: While rst_ni is low, gate_o, ton_fault_o and soft_start_o are all 0.
- R2: A demagnetization edge is a 0-to-1 change of demag_i between two consecutive clock samples. When an edge arrives with the clamp expired, blanking over, and skip_i, fault_i and ton_fault_o all low, gate_o goes high one clock later.
- R3: A demagnetization edge that arrives before CLAMP_CYC clocks have passed since the last turn-on is ignored. gate_o stays low, and a later valid edge starts the period.
- R4: A demagnetization edge within BLANK_CYC clocks after turn-off is ignored, even when the clamp has expired.
- R5: With no demagnetization edge after turn-off, gate_o rises on the (VTMO_CYC+1)-th clock after the turn-off edge. The valley timeout is restarted by every demagnetization edge, and while the gate is high.
- R6: Once the leading-edge window is over, a high cs_trip_i ends the on-time, and gate_o is low one clock later.
- R7: cs_trip_i is ignored for the first LEB_CYC clocks of each on-time. With cs_trip_i held high from turn-on, gate_o is high for exactly LEB_CYC+1 clocks.
- R8: A high skip_i forces gate_o low one clock later and blocks every restart while it stays high.
- R9: The first turn-on after skip_i has been high raises soft_start_o for exactly one clock, together with the rising gate. Every other turn-on leaves soft_start_o low.
- R10: If gate_o stays high for MAXON_CYC+1 clocks, it is driven low and ton_fault_o is set in the same clock. ton_fault_o then stays high until reset, and no further pulses occur.
- R11: gate_o is low in the same cycle that fault_i is high. While fault_i is high no restart occurs, and normal restarts resume after it falls.
- R12: Any two rising edges of gate_o are at least CLAMP_CYC+1 clocks apart, whatever caused the restart (valley edge, timeout or skip release).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_trip_i | input | 1 | Current-sense comparator tripped (peak reached) |
| demag_i | input | 1 | Auxiliary winding below zero-crossing threshold |
| skip_i | input | 1 | Burst-mode skip request, holds drive in reset |
| fault_i | input | 1 | External fault, forces the gate low at once |
| gate_o | output | 1 | Gate-drive command |
| ton_fault_o | output | 1 | Maximum on-time exceeded (sticky until reset) |
| soft_start_o | output | 1 | One-cycle soft-start request on the restart after skip |

## Verification
The assertions take for granted that all four inputs are synchronous to clk_i and already free of glitches. They also assume LEB_CYC is at least one, so that a fresh turn-on cannot be ended by the current trip in its first clock. The stimulus changes every input only on the falling clock edge, so each value holds steady across the rising edge that samples it. Faults and skip requests are applied as levels lasting whole cycles.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

    typedef struct packed {
        logic drv;
        logic soft_start;
        logic ton_fault;
        logic skip_seen;
    } seq_state_t;

    localparam seq_state_t SEQ_IDLE = '{drv: 1'b0, soft_start: 1'b0, ton_fault: 1'b0, skip_seen: 1'b0};

endpackage

// File: rtl/qr_sat_counter.sv
module qr_sat_counter #(
    parameter int unsigned LIMIT      = 16,
    parameter bit          START_DONE = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    output logic done_o
);
    localparam int unsigned   CW    = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
    localparam logic [CW-1:0] RST_V = START_DONE ? LIM_V : '0;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (cnt_q != LIM_V) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= RST_V;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == LIM_V);

endmodule

// File: rtl/qr_edge_det.sv
module qr_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = sig_i && !prev_q;

endmodule

// File: rtl/qr_restart_seq.sv
module qr_restart_seq
    import qr_seq_pkg::*;
#(
    parameter int unsigned CLAMP_CYC = 2000,
    parameter int unsigned BLANK_CYC = 750,
    parameter int unsigned VTMO_CYC  = 2000,
    parameter int unsigned LEB_CYC   = 92,
    parameter int unsigned MAXON_CYC = 11250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_trip_i,
    input  logic demag_i,
    input  logic skip_i,
    input  logic fault_i,
    output logic gate_o,
    output logic ton_fault_o,
    output logic soft_start_o
);
    seq_state_t st_d, st_q;

    logic demag_rise;
    logic clamp_done, blank_done, vtmo_done, leb_done, maxon_done;
    logic set_req, end_req, ton_trip, hold_off;
    logic vtmo_clr, on_clr;

    qr_edge_det u_demag_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (demag_i),
        .rise_o (demag_rise)
    );

    // cycles since the last turn-on (period clamp)
    qr_sat_counter #(.LIMIT(CLAMP_CYC), .START_DONE(1'b1)) u_clamp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (set_req),
        .done_o  (clamp_done)
    );

    // cycles since turn-off (leakage blanking)
    qr_sat_counter #(.LIMIT(BLANK_CYC), .START_DONE(1'b1)) u_blank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (st_q.drv),
        .done_o  (blank_done)
    );

    // cycles since the last valley edge while off (decayed ringing)
    qr_sat_counter #(.LIMIT(VTMO_CYC), .START_DONE(1'b0)) u_vtmo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (vtmo_clr),
        .done_o  (vtmo_done)
    );

    // on-time: leading-edge window
    qr_sat_counter #(.LIMIT(LEB_CYC), .START_DONE(1'b0)) u_leb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (on_clr),
        .done_o  (leb_done)
    );

    // on-time: maximum duration guard
    qr_sat_counter #(.LIMIT(MAXON_CYC), .START_DONE(1'b0)) u_maxon (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (on_clr),
        .done_o  (maxon_done)
    );

    always_comb begin
        vtmo_clr = st_q.drv || demag_rise;
        on_clr   = !st_q.drv;

        hold_off = skip_i || fault_i || st_q.ton_fault;
        ton_trip = st_q.drv && maxon_done;

        set_req  = !st_q.drv && clamp_done && blank_done
                   && (demag_rise || vtmo_done) && !hold_off;
        end_req  = st_q.drv && (hold_off || ton_trip || (cs_trip_i && leb_done));

        st_d = st_q;
        if (set_req) begin
            st_d.drv = 1'b1;
        end else if (end_req) begin
            st_d.drv = 1'b0;
        end

        st_d.ton_fault  = st_q.ton_fault || ton_trip;
        st_d.soft_start = set_req && st_q.skip_seen;

        if (skip_i) begin
            st_d.skip_seen = 1'b1;
        end else if (set_req) begin
            st_d.skip_seen = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o       = st_q.drv && !fault_i;
    assign ton_fault_o  = st_q.ton_fault;
    assign soft_start_o = st_q.soft_start;

endmodule

// File: rtl/qr_restart_seq_chk.sv
module qr_restart_seq_chk #(
    parameter int unsigned CLAMP_CYC = 2000,
    parameter int unsigned LEB_CYC   = 92,
    parameter int unsigned MAXON_CYC = 11250
) (
    input logic clk_i,
    input logic rst_ni,
    input logic skip_i,
    input logic fault_i,
    input logic gate_o,
    input logic ton_fault_o,
    input logic soft_start_o
);
    logic        prev_q;
    int unsigned gap_q;
    int unsigned on_len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q   <= 1'b0;
            gap_q    <= CLAMP_CYC + 1;
            on_len_q <= 0;
        end else begin
            prev_q <= gate_o;
            if (gate_o && !prev_q) begin
                gap_q <= 1;
            end else if (gap_q < CLAMP_CYC + 1) begin
                gap_q <= gap_q + 1;
            end
            if (!gate_o) begin
                on_len_q <= 0;
            end else if (on_len_q < MAXON_CYC + 2) begin
                on_len_q <= on_len_q + 1;
            end
        end
    end

    // R11
    fault_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |-> !gate_o);

    // R8
    skip_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        skip_i |=> !gate_o);

    // R12
    clamp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_o && !prev_q) |-> (gap_q >= CLAMP_CYC + 1));

    // R10
    maxon_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_o |-> (on_len_q <= MAXON_CYC + 1));

    // R10
    tf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ton_fault_o |=> ton_fault_o);

    // R10
    tf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ton_fault_o |-> !gate_o);

    // R9
    ss_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_start_o && !fault_i) |-> (gate_o && !prev_q));

    generate
        if (LEB_CYC > 0) begin : g_leb
            // R7
            leb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (gate_o && !prev_q && !skip_i && !fault_i) |=> (gate_o || fault_i));
        end
    endgenerate

endmodule

bind qr_restart_seq qr_restart_seq_chk #(
    .CLAMP_CYC (CLAMP_CYC),
    .LEB_CYC   (LEB_CYC),
    .MAXON_CYC (MAXON_CYC)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .skip_i       (skip_i),
    .fault_i      (fault_i),
    .gate_o       (gate_o),
    .ton_fault_o  (ton_fault_o),
    .soft_start_o (soft_start_o)
);

// File: tb/qr_restart_seq_tb.sv
`timescale 1ns/1ps
module qr_restart_seq_tb;
    localparam int unsigned CLAMP = 40;
    localparam int unsigned BLANK = 12;
    localparam int unsigned VTMO  = 60;
    localparam int unsigned LEB   = 4;
    localparam int unsigned MAXON = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, demag = 1'b0, skip = 1'b0, fault = 1'b0;
    logic gate, tfault, ss;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(negedge clk) cyc++;

    qr_restart_seq #(
        .CLAMP_CYC (CLAMP), .BLANK_CYC (BLANK), .VTMO_CYC (VTMO),
        .LEB_CYC (LEB), .MAXON_CYC (MAXON)
    ) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .cs_trip_i (cs), .demag_i (demag),
        .skip_i (skip), .fault_i (fault), .gate_o (gate),
        .ton_fault_o (tfault), .soft_start_o (ss)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cs = 0; demag = 0; skip = 0; fault = 0;
        wait_n(3);
        chk(gate == 0, "R1 gate", int'(gate), 0);
        chk(tfault == 0, "R1 ton_fault", int'(tfault), 0);
        chk(ss == 0, "R1 soft_start", int'(ss), 0);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic valley_edge();
        demag = 1'b1;
        @(negedge clk);
        demag = 1'b0;
    endtask

    task automatic trip();
        cs = 1'b1;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic t_basic();
        do_reset();
        valley_edge();
        chk(gate == 1, "R2 valley turn-on", int'(gate), 1);
        chk(ss == 0, "R9 no soft-start", int'(ss), 0);
        wait_n(10);
        trip();
        chk(gate == 0, "R6 cs turn-off", int'(gate), 0);
    endtask

    task automatic t_clamp();
        int t0;
        do_reset();
        valley_edge();
        t0 = cyc;
        wait_n(5);
        trip();
        wait_n(20);
        valley_edge();
        chk(gate == 0, "R3 early edge ignored", int'(gate), 0);
        wait_n(20);
        valley_edge();
        chk(gate == 1, "R3 later edge accepted", int'(gate), 1);
        chk((cyc - t0) >= CLAMP + 1, "R12 period gap", cyc - t0, CLAMP + 1);
    endtask

    task automatic t_blank();
        do_reset();
        valley_edge();
        wait_n(50);
        trip();
        wait_n(2);
        valley_edge();
        chk(gate == 0, "R4 blanked edge", int'(gate), 0);
        wait_n(15);
        valley_edge();
        chk(gate == 1, "R4 edge after blank", int'(gate), 1);
    endtask

    task automatic t_timeout();
        int t0;
        int n;
        do_reset();
        valley_edge();
        t0 = cyc;
        wait_n(50);
        trip();
        chk(gate == 0, "R6 turn-off", int'(gate), 0);
        n = 0;
        while (!gate && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(n == VTMO + 1, "R5 timeout restart", n, VTMO + 1);
        chk((cyc - t0) >= CLAMP + 1, "R12 timeout gap", cyc - t0, CLAMP + 1);
        chk(ss == 0, "R9 no soft-start on timeout", int'(ss), 0);
    endtask

    task automatic t_leb();
        int n;
        do_reset();
        cs = 1'b1;
        valley_edge();
        n = 0;
        while (gate && n < 200) begin
            @(negedge clk);
            n++;
        end
        cs = 1'b0;
        chk(n == LEB + 1, "R7 blanked on-time", n, LEB + 1);
    endtask

    task automatic t_skip();
        int bad;
        do_reset();
        valley_edge();
        wait_n(3);
        skip = 1'b1;
        @(negedge clk);
        chk(gate == 0, "R8 skip forces off", int'(gate), 0);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            if (i == 20 || i == 45) valley_edge();
            else @(negedge clk);
            if (gate) bad++;
        end
        chk(bad == 0, "R8 restarts blocked", bad, 0);
        skip = 1'b0;
        wait_n(2);
        valley_edge();
        chk(gate == 1, "R9 restart after skip", int'(gate), 1);
        chk(ss == 1, "R9 soft-start pulse", int'(ss), 1);
        @(negedge clk);
        chk(ss == 0, "R9 pulse one cycle", int'(ss), 0);
    endtask

    task automatic t_maxon();
        int n;
        do_reset();
        valley_edge();
        n = 0;
        while (gate && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(n == MAXON + 1, "R10 on-time limit", n, MAXON + 1);
        chk(tfault == 1, "R10 fault flag", int'(tfault), 1);
        wait_n(20);
        valley_edge();
        chk(gate == 0, "R10 no pulse after fault", int'(gate), 0);
        wait_n(100);
        chk(gate == 0, "R10 no timeout pulse", int'(gate), 0);
        chk(tfault == 1, "R10 flag sticky", int'(tfault), 1);
    endtask

    task automatic t_fault();
        int bad;
        do_reset();
        valley_edge();
        wait_n(3);
        fault = 1'b1;
        #1;
        chk(gate == 0, "R11 immediate off", int'(gate), 0);
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            if (i == 40) valley_edge();
            else @(negedge clk);
            if (gate) bad++;
        end
        chk(bad == 0, "R11 restarts blocked", bad, 0);
        fault = 1'b0;
        @(negedge clk);
        valley_edge();
        chk(gate == 1, "R11 resume after fault", int'(gate), 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        t_basic();
        t_clamp();
        t_blank();
        t_timeout();
        t_leb();
        t_skip();
        t_maxon();
        t_fault();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

endmodule